// File: doc/BRIEF.md
# Tri-Level Pulse Direction Decoder

This block turns one control line into count strobes. A comparator stage ahead of the block has already reduced the line to three levels: a low side, a high side and a mid-level rest state. The block sees them as two flags. A separate flag marks that the line has reached an over-voltage programming level. Every trip of the line away from mid and back is timed in clock cycles. A trip to the low side that is wide enough yields a one-cycle increment strobe. A trip to the high side yields a one-cycle decrement strobe.

Short glitches are thrown away. A pulse must be at least `VALID_CYC` samples wide to count. Any width below that, including the band between the glitch limit `REJ_CYC` and `VALID_CYC`, is also rejected, so the result never depends on where in that band a pulse falls. Counted pulses must be separated by a run of mid-level samples at least `GAP_CYC` long. Decoding only runs while the enable input is high.

The programming flag does two things: it blocks strobes, and it is passed on, registered, to the register controller that follows. All thresholds are parameters given in clock cycles. A parameter also picks whether the inputs pass through a sampling register first, which adds one cycle of latency to every output.

Top module: `tri_pulse_decoder`

## Requirements
- R1: A run of at least `VALID_CYC` consecutive low-side samples (lo_i=1, hi_i=0) followed by a mid sample raises inc_o for exactly one cycle. With IN_REG=0, inc_o is high in the cycle after the clock edge that sampled the mid level.
- R2: The same sequence on the high side (hi_i=1, lo_i=0) raises dec_o for exactly one cycle, with the same timing.
- R3: A pulse narrower than `VALID_CYC` samples produces no strobe. This holds both below `REJ_CYC` and in the band between `REJ_CYC` and `VALID_CYC`.
- R4: After a counted pulse ends, a new pulse counts only if at least `GAP_CYC` mid samples follow the sample that ended the counted pulse and come before the new pulse's first sample. A rejected pulse does not restart this spacing; its samples merely pause it.
- R5: While en_i is low, no strobe is produced and any pulse in progress is dropped. On re-enable, the spacing rule of R4 is treated as already met.
- R6: If prog_i is high on any sample of a pulse, or on the mid sample that ends it, no strobe is produced. prog_o follows prog_i, delayed by one cycle when IN_REG=0.
- R7: Level coding is: lo_i alone is low, hi_i alone is high, and both or neither is mid. A change from one side directly to the other, with no mid sample between, drops the first pulse and starts timing the second.
- R8: During and after reset, inc_o, dec_o and prog_o are 0. The first pulse after reset needs no preceding mid spacing.
- R9: A pulse much longer than `VALID_CYC` still yields a single one-cycle strobe. inc_o and dec_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Decoding enable |
| lo_i | input | 1 | Line is at the low-side level |
| hi_i | input | 1 | Line is at the high-side level |
| prog_i | input | 1 | Line is at the programming level |
| inc_o | output | 1 | One-cycle increment strobe |
| dec_o | output | 1 | One-cycle decrement strobe |
| prog_o | output | 1 | Registered programming-level flag for the register controller |

## Verification
The bench builds the decoder with REJ_CYC=3, VALID_CYC=8, GAP_CYC=5 and IN_REG=0. These values keep every window short enough that the bench can step through it sample by sample. Pulses of exactly 8 and 7 samples, a 2-sample glitch, and mid runs of exactly 5 and 4 samples all fit within a few dozen cycles. The small values also let a rejected pulse placed between two counted ones show that the spacing keeps accumulating rather than restarting.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
   typedef enum logic [1:0] {
      SIDE_MID  = 2'd0,
      SIDE_LOW  = 2'd1,
      SIDE_HIGH = 2'd2
   } side_e;

   // One flag alone selects its side; both or neither reads as rest level.
   function automatic side_e classify(input logic lo, input logic hi);
      if (lo && !hi)      return SIDE_LOW;
      else if (hi && !lo) return SIDE_HIGH;
      else                return SIDE_MID;
   endfunction
endpackage

// File: rtl/tpd_level_map.sv
module tpd_level_map
   import tpd_pkg::*;
#(
   parameter int IN_REG = 0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lo_i,
   input  logic  hi_i,
   input  logic  prog_i,
   output side_e side_o,
   output logic  prog_o
);
   generate
      if (IN_REG != 0) begin : g_reg
         side_e side_q;
         logic  prog_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               side_q <= SIDE_MID;
               prog_q <= 1'b0;
            end else begin
               side_q <= classify(lo_i, hi_i);
               prog_q <= prog_i;
            end
         end
         assign side_o = side_q;
         assign prog_o = prog_q;
      end else begin : g_comb
         assign side_o = classify(lo_i, hi_i);
         assign prog_o = prog_i;
      end
   endgenerate
endmodule

// File: rtl/tpd_span_timer.sv
module tpd_span_timer #(
   parameter int W       = 8,
   parameter int MAX     = 255,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAX_V = W'(MAX);
   localparam logic [W-1:0] RST_V = W'(RST_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n)                       count <= RST_V;
      else if (load)                    count <= load_val;
      else if (step && count != MAX_V)  count <= count + 1'b1;
   end
endmodule

// File: rtl/tri_pulse_decoder.sv
module tri_pulse_decoder
   import tpd_pkg::*;
#(
   parameter int REJ_CYC   = 20,
   parameter int VALID_CYC = 200,
   parameter int GAP_CYC   = 10,
   parameter int IN_REG    = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic lo_i,
   input  logic hi_i,
   input  logic prog_i,
   output logic inc_o,
   output logic dec_o,
   output logic prog_o
);
   localparam int WCW = $clog2(VALID_CYC + 1);
   localparam int GCW = $clog2(GAP_CYC + 1);
   localparam logic [WCW-1:0] VALID_V = WCW'(VALID_CYC);
   localparam logic [GCW-1:0] GAP_V   = GCW'(GAP_CYC);

   generate
      if (REJ_CYC < 1 || VALID_CYC <= REJ_CYC || GAP_CYC < 1 || IN_REG < 0 || IN_REG > 1) begin : g_bad_cfg
         $error("tri_pulse_decoder: need 1 <= REJ_CYC < VALID_CYC, GAP_CYC >= 1, IN_REG in {0,1}");
      end
   endgenerate

   side_e lvl;
   logic  prog_s;

   tpd_level_map #(.IN_REG(IN_REG)) u_map (
      .clk(clk), .rst_n(rst_n), .lo_i(lo_i), .hi_i(hi_i), .prog_i(prog_i),
      .side_o(lvl), .prog_o(prog_s)
   );

   side_e          side_q;
   logic           taint_q, spaced_q;
   logic [WCW-1:0] wcnt;
   logic [GCW-1:0] gcnt;
   logic           start, hold, finish, accept;

   always_comb begin
      start  = en_i && (lvl != SIDE_MID) && (lvl != side_q);
      hold   = en_i && (lvl == side_q) && (side_q != SIDE_MID);
      finish = en_i && (side_q != SIDE_MID) && (lvl == SIDE_MID);
      accept = finish && (wcnt == VALID_V) && !taint_q && !prog_s && spaced_q;
   end

   tpd_span_timer #(.W(WCW), .MAX(VALID_CYC), .RST_VAL(0)) u_width (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(WCW'(1)),
      .step(hold), .count(wcnt)
   );

   tpd_span_timer #(.W(GCW), .MAX(GAP_CYC), .RST_VAL(GAP_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n),
      .load(!en_i || accept), .load_val(en_i ? '0 : GAP_V),
      .step(lvl == SIDE_MID), .count(gcnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         side_q   <= SIDE_MID;
         taint_q  <= 1'b0;
         spaced_q <= 1'b0;
         inc_o    <= 1'b0;
         dec_o    <= 1'b0;
         prog_o   <= 1'b0;
      end else begin
         prog_o <= prog_s;
         inc_o  <= accept && (side_q == SIDE_LOW);
         dec_o  <= accept && (side_q == SIDE_HIGH);
         if (!en_i || finish) begin
            side_q <= SIDE_MID;
         end else if (start) begin
            side_q   <= lvl;
            taint_q  <= prog_s;
            spaced_q <= (gcnt == GAP_V);
         end else if (hold) begin
            taint_q  <= taint_q | prog_s;
         end
      end
   end
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
   parameter int VALID_CYC = 200,
   parameter int GAP_CYC   = 10,
   parameter int LAT       = 0
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic lo_i,
   input logic hi_i,
   input logic prog_i,
   input logic inc_o,
   input logic dec_o,
   input logic prog_o
);
   localparam int RW   = $clog2(VALID_CYC + 1);
   localparam int SPAN = GAP_CYC + VALID_CYC;
   localparam int SW   = $clog2(SPAN + 1);
   localparam logic [RW-1:0] RMAX = RW'(VALID_CYC);
   localparam logic [SW-1:0] SMAX = SW'(SPAN);

   logic [RW-1:0] run_lo, run_hi, last_lo, last_hi;
   logic [SW-1:0] since;
   logic lo_only, hi_only;
   assign lo_only = lo_i & ~hi_i;
   assign hi_only = hi_i & ~lo_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_lo <= '0; run_hi <= '0; last_lo <= '0; last_hi <= '0;
         since  <= SMAX;
      end else begin
         run_lo <= lo_only ? ((run_lo == RMAX) ? run_lo : run_lo + 1'b1) : '0;
         run_hi <= hi_only ? ((run_hi == RMAX) ? run_hi : run_hi + 1'b1) : '0;
         if (!lo_only && run_lo != '0) last_lo <= run_lo;
         if (!hi_only && run_hi != '0) last_hi <= run_hi;
         if (!en_i)                   since <= SMAX;
         else if (inc_o || dec_o)     since <= '0;
         else if (since != SMAX)      since <= since + 1'b1;
      end
   end

   // R1 / R2: strobe direction follows the side visited just before the return
   assert_inc_from_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      inc_o |-> ($past(lo_i, 2 + LAT) && !$past(hi_i, 2 + LAT)));
   assert_dec_from_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_o |-> ($past(hi_i, 2 + LAT) && !$past(lo_i, 2 + LAT)));
   // R3: a strobe needs a full-width run on its side
   assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o |-> last_lo == RMAX) and (dec_o |-> last_hi == RMAX));
   // R4: counted pulses are spaced by gap plus width
   assert_count_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o || dec_o) |-> since == SMAX);
   // R5: no strobe decided while disabled
   assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> (!inc_o && !dec_o));
   // R6: programming level blocks strobes and is forwarded
   assert_prog_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o || dec_o) |-> !$past(prog_i, 1 + LAT));
   assert_prog_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_o == $past(prog_i, 1 + LAT));
   // R9: strobes last one cycle and never coincide
   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o || dec_o) |=> (!inc_o && !dec_o));
endmodule

bind tri_pulse_decoder tpd_checker #(
   .VALID_CYC(VALID_CYC), .GAP_CYC(GAP_CYC), .LAT(IN_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .lo_i(lo_i), .hi_i(hi_i),
   .prog_i(prog_i), .inc_o(inc_o), .dec_o(dec_o), .prog_o(prog_o)
);

// File: tb/tri_pulse_decoder_test.sv
`timescale 1ns/1ps
module tri_pulse_decoder_test;
   logic clk = 1'b0;
   logic rst_n, en_i, lo_i, hi_i, prog_i;
   logic inc_o, dec_o, prog_o;
   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   tri_pulse_decoder #(.REJ_CYC(3), .VALID_CYC(8), .GAP_CYC(5), .IN_REG(0)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .lo_i(lo_i), .hi_i(hi_i),
      .prog_i(prog_i), .inc_o(inc_o), .dec_o(dec_o), .prog_o(prog_o)
   );

   // fields: [19:12] mid samples before, [11:10] side (1 low, 2 high),
   //         [9:2] width, [1] expected inc, [0] expected dec
   localparam logic [19:0] VEC [9] = '{
      {8'd2, 2'd1, 8'd8,  1'b1, 1'b0},   // R8 first pulse, R1 exact width
      {8'd4, 2'd2, 8'd8,  1'b0, 1'b1},   // R2, R4 spacing exactly met
      {8'd4, 2'd1, 8'd7,  1'b0, 1'b0},   // R3 between thresholds
      {8'd4, 2'd1, 8'd2,  1'b0, 1'b0},   // R3 glitch
      {8'd0, 2'd2, 8'd20, 1'b0, 1'b1},   // R9 long pulse
      {8'd3, 2'd1, 8'd10, 1'b0, 1'b0},   // R4 spacing one short
      {8'd0, 2'd1, 8'd10, 1'b1, 1'b0},   // R4 spacing kept across rejected pulse
      {8'd5, 2'd2, 8'd9,  1'b0, 1'b1},   // R2
      {8'd5, 2'd2, 8'd3,  1'b0, 1'b0}    // R3
   };

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // s: 0 mid, 1 low, 2 high, 3 both flags; one sampled edge per step
   task automatic drive(input int s, input int n);
      for (int i = 0; i < n; i++) begin
         lo_i = (s == 1) || (s == 3);
         hi_i = (s == 2) || (s == 3);
         @(negedge clk);
      end
   endtask

   task automatic pulse(input int s, input int w, input logic ei, input logic ed, input string req);
      drive(s, w);
      drive(0, 1);
      chk(req, {inc_o, dec_o}, {ei, ed});
      drive(0, 1);
      chk({req, " R9 one-cycle"}, {inc_o, dec_o}, 2'b00);
   endtask

   initial begin
      #1000000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en_i = 1'b1; lo_i = 1'b0; hi_i = 1'b0; prog_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 reset strobes", {inc_o, dec_o}, 2'b00);
      chk("R8 reset prog_o", {1'b0, prog_o}, 2'b00);
      rst_n = 1'b1;

      for (int v = 0; v < 9; v++) begin
         drive(0, int'(VEC[v][19:12]));
         pulse(int'(VEC[v][11:10]), int'(VEC[v][9:2]), VEC[v][1], VEC[v][0],
               $sformatf("R1/R2/R3/R4 vector %0d", v));
      end

      // R5: disabled, a valid pulse is ignored
      en_i = 1'b0;
      pulse(1, 10, 1'b0, 1'b0, "R5 disabled");
      en_i = 1'b1;
      drive(0, 5);
      // R5: pulse broken by a disabled sample is dropped; remainder too short
      drive(1, 4);
      en_i = 1'b0; drive(1, 1); en_i = 1'b1;
      pulse(1, 6, 1'b0, 1'b0, "R5 abort");
      drive(0, 5);
      // R5: re-enable restores spacing credit right after a count
      pulse(2, 8, 1'b0, 1'b1, "R2 before disable");
      en_i = 1'b0; drive(0, 1); en_i = 1'b1;
      pulse(1, 8, 1'b1, 1'b0, "R5 re-enable spacing");

      // R6: programming level inside a pulse
      drive(0, 5);
      drive(1, 3); prog_i = 1'b1; drive(1, 1); prog_i = 1'b0;
      pulse(1, 6, 1'b0, 1'b0, "R6 prog mid-pulse");
      // R6: programming level on the returning sample, then forwarding
      drive(0, 3);
      drive(1, 8);
      prog_i = 1'b1;
      drive(0, 1);
      chk("R6 prog on return", {inc_o, dec_o}, 2'b00);
      chk("R6 prog_o high", {1'b0, prog_o}, 2'b01);
      prog_i = 1'b0;
      drive(0, 1);
      chk("R6 prog_o low", {1'b0, prog_o}, 2'b00);

      // R7: direct low-to-high swap counts only the high pulse
      drive(0, 5);
      drive(1, 5);
      pulse(2, 8, 1'b0, 1'b1, "R7 swap");
      // R7: both flags read as mid and end a low pulse
      drive(0, 5);
      drive(1, 8);
      drive(3, 1);
      chk("R7 both flags end pulse", {inc_o, dec_o}, 2'b10);
      drive(0, 1);
      chk("R7 R9 one-cycle", {inc_o, dec_o}, 2'b00);
      // R7: both flags held long is rest level
      drive(0, 5);
      pulse(3, 12, 1'b0, 1'b0, "R7 both flags as mid");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule